// File: doc/BRIEF.md
# Cascadable Serial Register Port

This block is the serial control target of a device that can be placed in a chain of up to sixteen identical devices. All devices in the chain share the serial clock and one active-low select. The host's data line enters the first device, and each device passes the stream on to the next through a forwarding output. Every access carries three bytes on the wire, most significant bit first: a control byte, a register address byte and a data byte. The control byte holds a broadcast flag, a read/write flag and a four-bit channel number.

Each device lowers the channel number by one as the number passes through it. The device that receives the number zero takes the access, so the host reaches device k by sending k. A broadcast write passes the number on unchanged and is stored by every device. Register contents are modelled as a plain register file that is reset to zero. The serial pins are oversampled by the system clock and pass through a synchronizer. A separate enable pin goes with the serial output so that the pad ring can tri-state it.

Two host framings are accepted. A byte-wide host raises the select after each byte, and the access carries on across those gaps. A word-wide host keeps the select low for two 16-bit words, where the fourth byte is filler and is ignored.

Top module: `chain_spi_regport`

States of the access sequencer:
- `ST_CTRL`: receives the control byte and goes to `ST_ADDR` after its eighth bit.
- `ST_ADDR`: receives the address byte and goes to `ST_DATA` after its eighth bit. For a selected read it also loads the read data.
- `ST_DATA`: receives or sends the data byte, commits a write, and goes to `ST_TAIL` after its eighth bit.
- `ST_TAIL`: ignores any further clocks.

Transitions back to `ST_CTRL` happen on an abort (select raised with a partial byte) and when the select goes inactive in `ST_TAIL`.

## Requirements
- R1: Control byte layout on the wire:
  - bit 7 is broadcast.
  - bit 6 is read when 1 and write when 0.
  - bits 5 down to 2 hold the channel number, with its bit 0 in bit 5 and its bit 3 in bit 2.
  - bits 1:0 are ignored.
  A non-broadcast access is taken only by the device that receives the channel number 0.
- R2: `spi_dthru` equals `spi_din` at every sampling point. The one exception is the channel bits of a non-broadcast control byte, where the forwarded number is the received number minus one, modulo 16.
- R3: A broadcast control byte is forwarded unchanged. A broadcast write is stored in every device. A broadcast read enables no output.
- R4: A write stores the data byte into the register named by the address byte after the last data bit. An address at or above REG_DEPTH changes no register.
- R5: Read data leaves MSB first. Each bit is updated on an SCLK falling edge, starting with the falling edge that follows the sixteenth rising edge. An out-of-range address reads 0. SDI during the data byte of a read changes no register.
- R6: `spi_dout_en` is high only during the data byte of a read taken by this device, and only while `spi_csn` is low. It is low whenever `spi_csn` is high.
- R7: While `spi_csn` is high, SCLK and SDI activity changes no state.
- R8: With a byte-wide host, raising `spi_csn` at a byte boundary keeps the access going.
- R9: With a word-wide host, clocks that follow the data byte while the select stays low are ignored.
- R10: Raising `spi_csn` in the middle of a byte discards the access, and the next access starts from a control byte.
- R11: After reset every register reads 0 and `spi_dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_clk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Shared active-low select |
| spi_din | input | 1 | Serial data from the host or from the previous device |
| spi_dthru | output | 1 | Forwarded serial data to the next device |
| spi_dout | output | 1 | Serial read data |
| spi_dout_en | output | 1 | Output enable for `spi_dout` |

## Verification
The bench builds three chained instances with REG_DEPTH at 32 and SYNC_STAGES at 2. With that chain, channel numbers 0 to 2 select a device and larger numbers reach nobody. Addresses up to 35 exercise the out-of-range path. Both framings, broadcast, partial-byte aborts and clocking with the select high are all driven against a per-device register model.

// File: rtl/crp_pkg.sv
package crp_pkg;
    localparam int BYTE_W = 8;
    localparam int CH_W   = 4;
    // control byte bit positions (wire order is MSB first)
    localparam int BC_POS = 7;
    localparam int RW_POS = 6;
    localparam int CH_HI  = 5;   // carries channel bit 0, first on the wire
    localparam int CH_LO  = 2;   // carries channel bit 3

    typedef enum logic [1:0] {
        ST_CTRL,
        ST_ADDR,
        ST_DATA,
        ST_TAIL
    } crp_state_e;
endpackage

// File: rtl/crp_sampler.sv
module crp_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_clk,
    input  logic spi_csn,
    input  logic spi_din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel_act,
    output logic din_s
);
    logic [STAGES-1:0] clk_sy, sel_sy, din_sy;
    logic              clk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sy   <= '0;
            sel_sy   <= '0;
            din_sy   <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_sy   <= {clk_sy[STAGES-2:0], spi_clk};
            sel_sy   <= {sel_sy[STAGES-2:0], ~spi_csn};
            din_sy   <= {din_sy[STAGES-2:0], spi_din};
            clk_prev <= clk_sy[STAGES-1];
        end
    end

    assign sel_act   = sel_sy[STAGES-1];
    assign din_s     = din_sy[STAGES-1];
    assign sclk_rise = sel_act &  clk_sy[STAGES-1] & ~clk_prev;
    assign sclk_fall = sel_act & ~clk_sy[STAGES-1] &  clk_prev;
endmodule

// File: rtl/crp_regfile.sv
module crp_regfile #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem[wr_addr[AW-1:0]] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr[AW-1:0]] : '0;
endmodule

// File: rtl/chain_spi_regport.sv
module chain_spi_regport
    import crp_pkg::*;
#(
    parameter int REG_DEPTH   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_clk,
    input  logic spi_csn,
    input  logic spi_din,
    output logic spi_dthru,
    output logic spi_dout,
    output logic spi_dout_en
);
    localparam int          CW      = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST  = CW'(BYTE_W - 1);
    localparam logic [CW-1:0] BC_IX = CW'(BYTE_W - 1 - BC_POS);
    localparam logic [CW-1:0] RW_IX = CW'(BYTE_W - 1 - RW_POS);
    localparam logic [CW-1:0] CH_F  = CW'(BYTE_W - 1 - CH_HI);
    localparam logic [CW-1:0] CH_L  = CW'(BYTE_W - 1 - CH_LO);

    logic sclk_rise, sclk_fall, sel_act, bit_s;

    crp_state_e        st_q, st_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [BYTE_W-2:0] sh_q, sh_d;
    logic [BYTE_W-1:0] ad_q, ad_d, ob_q, ob_d;
    logic              bc_q, bc_d, rd_q, rd_d, hit_q, hit_d;
    logic              brw_q, brw_d, drv_q, drv_d, so_q, so_d;
    logic [BYTE_W-1:0] byte_in, rf_rdata;
    logic              byte_end, wr_en, in_win;

    crp_sampler #(.STAGES(SYNC_STAGES)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_clk  (spi_clk),
        .spi_csn  (spi_csn),
        .spi_din  (spi_din),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sel_act  (sel_act),
        .din_s    (bit_s)
    );

    assign byte_in  = {sh_q, bit_s};
    assign byte_end = sclk_rise && (cnt_q == LAST);
    assign wr_en    = byte_end && (st_q == ST_DATA) && !rd_q && (hit_q || bc_q);

    crp_regfile #(.DEPTH(REG_DEPTH), .DW(BYTE_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(ad_q),
        .wr_data(byte_in),
        .rd_addr(byte_in),
        .rd_data(rf_rdata)
    );

    // next-state process
    always_comb begin
        st_d  = st_q;  cnt_d = cnt_q; sh_d  = sh_q;  ad_d = ad_q;
        ob_d  = ob_q;  bc_d  = bc_q;  rd_d  = rd_q;  hit_d = hit_q;
        brw_d = brw_q; drv_d = drv_q; so_d  = so_q;
        if (!sel_act) begin
            // select gone: partial byte or finished access restarts the frame
            if (st_q == ST_TAIL || cnt_q != '0) begin
                st_d  = ST_CTRL;
                cnt_d = '0;
                drv_d = 1'b0;
            end
        end else if (sclk_rise) begin
            cnt_d = cnt_q + 1'b1;
            sh_d  = byte_in[BYTE_W-2:0];
            unique case (st_q)
                ST_CTRL: begin
                    if (cnt_q == BC_IX) bc_d = bit_s;
                    if (cnt_q == RW_IX) rd_d = bit_s;
                    if (cnt_q >= CH_F && cnt_q <= CH_L) brw_d = brw_q & ~bit_s;
                    if (byte_end) begin
                        hit_d = (byte_in[CH_HI:CH_LO] == '0);
                        st_d  = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (byte_end) begin
                        ad_d = byte_in;
                        st_d = ST_DATA;
                        if (rd_q && hit_q && !bc_q) begin
                            drv_d = 1'b1;
                            ob_d  = rf_rdata;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_end) begin
                        st_d  = ST_TAIL;
                        drv_d = 1'b0;
                    end
                end
                ST_TAIL: begin
                end
            endcase
        end else if (sclk_fall && drv_q) begin
            so_d = ob_q[BYTE_W-1];
            ob_d = {ob_q[BYTE_W-2:0], 1'b0};
        end
        if (st_q == ST_CTRL && cnt_q < CH_F) brw_d = 1'b1;
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_CTRL; cnt_q <= '0;   sh_q  <= '0;   ad_q  <= '0;
            ob_q  <= '0;      bc_q  <= 1'b0; rd_q  <= 1'b0; hit_q <= 1'b0;
            brw_q <= 1'b1;    drv_q <= 1'b0; so_q  <= 1'b0;
        end else begin
            st_q  <= st_d;  cnt_q <= cnt_d; sh_q  <= sh_d;  ad_q  <= ad_d;
            ob_q  <= ob_d;  bc_q  <= bc_d;  rd_q  <= rd_d;  hit_q <= hit_d;
            brw_q <= brw_d; drv_q <= drv_d; so_q  <= so_d;
        end
    end

    // output process
    always_comb begin
        in_win      = (st_q == ST_CTRL) && (cnt_q >= CH_F) && (cnt_q <= CH_L);
        spi_dthru   = spi_din ^ (in_win & ~bc_q & brw_q & ~spi_csn);
        spi_dout    = so_q;
        spi_dout_en = drv_q & ~spi_csn;
    end
endmodule

// File: rtl/crp_checker.sv
module crp_checker
    import crp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       spi_din,
    input logic       spi_dthru,
    input logic       spi_dout,
    input logic       spi_dout_en,
    input crp_state_e st_q,
    input logic [2:0] cnt_q,
    input logic       sel_act,
    input logic       sclk_fall,
    input logic       wr_en,
    input logic       drv_q,
    input logic       rd_q,
    input logic       hit_q,
    input logic       bc_q
);
    p_dout_en_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_dout_en |-> (st_q == ST_DATA));

    p_drive_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q) |-> (rd_q && hit_q && !bc_q));

    p_bcast_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_q && st_q == ST_DATA) |-> !drv_q);

    p_thru_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_CTRL) |-> (spi_dthru == spi_din));

    p_write_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q == ST_TAIL));

    p_abort_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_act && cnt_q != 3'd0) |=> (st_q == ST_CTRL && cnt_q == 3'd0));

    p_dout_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(spi_dout));
endmodule

bind chain_spi_regport crp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_din    (spi_din),
    .spi_dthru  (spi_dthru),
    .spi_dout   (spi_dout),
    .spi_dout_en(spi_dout_en),
    .st_q       (st_q),
    .cnt_q      (cnt_q),
    .sel_act    (sel_act),
    .sclk_fall  (sclk_fall),
    .wr_en      (wr_en),
    .drv_q      (drv_q),
    .rd_q       (rd_q),
    .hit_q      (hit_q),
    .bc_q       (bc_q)
);

// File: tb/sim_chain_spi_regport.sv
`timescale 1ns/1ps
module sim_chain_spi_regport;
    localparam int RD  = 32;
    localparam int NDV = 3;
    localparam int HP  = 6;
    localparam int GAP = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic t0, t1, t2, d0, d1, d2, e0, e1, e2;
    logic bus;
    logic [2:0] en_mask;
    int checks = 0, errors = 0;
    logic [7:0] mdl [NDV][RD];

    always #10 clk = ~clk;

    chain_spi_regport #(.REG_DEPTH(RD), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_clk(sclk), .spi_csn(csn), .spi_din(sdi),
        .spi_dthru(t0), .spi_dout(d0), .spi_dout_en(e0));
    chain_spi_regport #(.REG_DEPTH(RD), .SYNC_STAGES(2)) u1 (
        .clk(clk), .rst_n(rst_n), .spi_clk(sclk), .spi_csn(csn), .spi_din(t0),
        .spi_dthru(t1), .spi_dout(d1), .spi_dout_en(e1));
    chain_spi_regport #(.REG_DEPTH(RD), .SYNC_STAGES(2)) u2 (
        .clk(clk), .rst_n(rst_n), .spi_clk(sclk), .spi_csn(csn), .spi_din(t1),
        .spi_dthru(t2), .spi_dout(d2), .spi_dout_en(e2));

    assign bus = (e0 & d0) | (e1 & d1) | (e2 & d2);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R1: bit7 broadcast, bit6 read, bits5..2 = channel bit0..bit3
    function automatic logic [7:0] mk_ctrl(input bit bc, input bit rd, input logic [3:0] ch,
                                           input logic [1:0] rsv);
        return {bc, rd, ch[0], ch[1], ch[2], ch[3], rsv};
    endfunction

    // R2: forwarded control byte
    function automatic logic [7:0] fwd_ctrl(input logic [7:0] c);
        logic [3:0] ch, nx;
        if (c[7]) return c;
        ch = {c[2], c[3], c[4], c[5]};
        nx = ch - 4'd1;
        return {c[7:6], nx[0], nx[1], nx[2], nx[3], c[1:0]};
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic o, output logic t);
        sdi = b;
        wt(HP);
        o = bus;
        t = t0;
        en_mask |= {e2, e1, e0};
        sclk = 1'b1;
        wt(HP);
        sclk = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] o, output logic [7:0] t);
        for (int i = 7; i >= 0; i--) xbit(b[i], o[i], t[i]);
    endtask

    task automatic access(input bit w16, input logic [7:0] c, input logic [7:0] a,
                          input logic [7:0] d, output logic [7:0] rdv, output logic [7:0] thr);
        logic [7:0] o, t;
        en_mask = '0;
        if (w16) begin
            csn = 1'b0; wt(GAP);
            xbyte(c, o, thr);
            xbyte(a, o, t);
            xbyte(d, rdv, t);
            xbyte(8'($urandom), o, t);      // filler byte of the second word (R9)
            wt(GAP); csn = 1'b1; wt(GAP);
        end else begin
            csn = 1'b0; wt(GAP); xbyte(c, o, thr); wt(HP); csn = 1'b1; wt(GAP);
            csn = 1'b0; wt(GAP); xbyte(a, o, t);   wt(HP); csn = 1'b1; wt(GAP);
            if (c[6]) chk({e2, e1, e0} == 3'b000, "R6 enable with select high", {e2, e1, e0}, 0);
            csn = 1'b0; wt(GAP); xbyte(d, rdv, t); wt(HP); csn = 1'b1; wt(GAP);
        end
        chk({e2, e1, e0} == 3'b000, "R6 enable after access", {e2, e1, e0}, 0);
        chk(thr == fwd_ctrl(c), "R2 forwarded control byte", thr, fwd_ctrl(c));
    endtask

    task automatic do_write(input bit w16, input bit bc, input logic [3:0] ch,
                            input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r, t;
        access(w16, mk_ctrl(bc, 1'b0, ch, 2'($urandom)), a, d, r, t);
        chk(en_mask == 3'b000, "R6 write drives nothing", en_mask, 0);
        if (int'(a) < RD) begin
            if (bc) begin
                for (int k = 0; k < NDV; k++) mdl[k][a] = d;
            end else if (int'(ch) < NDV) begin
                mdl[ch][a] = d;
            end
        end
    endtask

    task automatic do_read(input bit w16, input bit bc, input logic [3:0] ch,
                           input logic [7:0] a, input logic [7:0] junk, input string tag);
        logic [7:0] r, t, ex;
        logic [2:0] em;
        access(w16, mk_ctrl(bc, 1'b1, ch, 2'($urandom)), a, junk, r, t);
        ex = '0;
        em = '0;
        if (!bc && int'(ch) < NDV) begin
            em = 3'(1 << ch);
            if (int'(a) < RD) ex = mdl[ch][a];
        end
        chk(en_mask == em, "R6 enable mask", en_mask, em);
        chk(r == ex, tag, r, ex);
    endtask

    task automatic partial(input logic [7:0] c, input int nbytes, input int nbits);
        logic [7:0] o, t;
        logic ob, tb;
        csn = 1'b0; wt(GAP);
        xbyte(c, o, t);
        if (nbytes > 1) xbyte(8'd3, o, t);
        for (int i = 0; i < nbits; i++) xbit(1'b1, ob, tb);
        wt(HP); csn = 1'b1; wt(GAP);
    endtask

    initial begin
        logic ob, tb;
        for (int k = 0; k < NDV; k++)
            for (int i = 0; i < RD; i++) mdl[k][i] = '0;
        void'($urandom(32'd20240611));
        wt(5);
        rst_n = 1'b1;
        wt(5);

        // R11 reset state
        chk({e2, e1, e0} == 3'b000, "R11 enable at reset", {e2, e1, e0}, 0);
        do_read(1'b0, 1'b0, 4'd0, 8'd0, 8'h00, "R11 dev0 reg0");
        do_read(1'b1, 1'b0, 4'd2, 8'd31, 8'h00, "R11 dev2 reg31");

        // R1 / R8 / R9 addressing through the chain
        do_write(1'b0, 1'b0, 4'd1, 8'd5, 8'h3C);
        do_read(1'b1, 1'b0, 4'd1, 8'd5, 8'h00, "R1 dev1 written");
        do_read(1'b0, 1'b0, 4'd0, 8'd5, 8'h00, "R1 dev0 untouched");
        do_read(1'b1, 1'b0, 4'd2, 8'd5, 8'h00, "R1 dev2 untouched");
        do_write(1'b1, 1'b0, 4'd9, 8'd6, 8'hEE);   // channel reaches nobody
        for (int k = 0; k < NDV; k++) do_read(1'b0, 1'b0, 4'(k), 8'd6, 8'h00, "R1 no match");

        // R3 broadcast
        do_write(1'b1, 1'b1, 4'd2, 8'd7, 8'h81);
        for (int k = 0; k < NDV; k++) do_read(1'b1, 1'b0, 4'(k), 8'd7, 8'h00, "R3 broadcast write");
        do_read(1'b0, 1'b1, 4'd0, 8'd7, 8'h00, "R3 broadcast read");

        // R4 / R5 out of range
        do_write(1'b0, 1'b0, 4'd0, 8'd40, 8'h55);
        do_read(1'b1, 1'b0, 4'd0, 8'd40, 8'h00, "R5 out of range reads 0");
        do_read(1'b0, 1'b0, 4'd0, 8'd8, 8'h00, "R4 out of range no alias");

        // R5 SDI ignored during read data byte
        do_write(1'b1, 1'b0, 4'd2, 8'd9, 8'hA6);
        do_read(1'b1, 1'b0, 4'd2, 8'd9, 8'hFF, "R5 read data");
        do_read(1'b0, 1'b0, 4'd2, 8'd9, 8'h00, "R5 register unchanged by read");

        // R10 abort in data byte and in control byte
        do_write(1'b0, 1'b0, 4'd0, 8'd3, 8'h12);
        partial(mk_ctrl(1'b0, 1'b0, 4'd0, 2'b00), 2, 3);
        do_read(1'b1, 1'b0, 4'd0, 8'd3, 8'h00, "R10 aborted write discarded");
        csn = 1'b0; wt(GAP);
        for (int i = 0; i < 4; i++) xbit(1'b1, ob, tb);
        wt(HP); csn = 1'b1; wt(GAP);
        do_write(1'b0, 1'b0, 4'd0, 8'd3, 8'h34);
        do_read(1'b0, 1'b0, 4'd0, 8'd3, 8'h00, "R10 fresh access after abort");

        // R7 clocks with the select high
        for (int i = 0; i < 20; i++) begin
            sdi = 1'($urandom);
            wt(3); sclk = 1'b1; wt(3); sclk = 1'b0;
            en_mask |= {e2, e1, e0};
        end
        chk({e2, e1, e0} == 3'b000, "R7 idle clocks drive nothing", {e2, e1, e0}, 0);
        do_read(1'b1, 1'b0, 4'd1, 8'd5, 8'h00, "R7 state intact after idle clocks");

        // random mix of both framings
        for (int n = 0; n < 70; n++) begin
            bit w16, bc, rd;
            logic [3:0] ch;
            logic [7:0] a;
            w16 = 1'($urandom);
            bc  = ($urandom % 8) == 0;
            rd  = 1'($urandom);
            ch  = 4'($urandom % 5);
            a   = 8'($urandom % 36);
            if (rd) do_read(w16, bc, ch, a, 8'($urandom), "R5 random read");
            else    do_write(w16, bc, ch, a, 8'($urandom));
        end
        for (int k = 0; k < NDV; k++)
            for (int i = 0; i < RD; i += 5)
                do_read(1'($urandom), 1'b0, 4'(k), 8'(i), 8'h00, "R4 final sweep");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule